// File: doc/BRIEF.md
# Triple-Channel Speed Disagreement Monitor

This block watches three redundant speed measurements and decides, sample by sample, which of them can be trusted. Each channel gets a range check in every cycle. On every sample strobe, each channel is also compared against the other two. A channel that stays an isolated outlier for a programmable number of consecutive samples is declared faulty. The fault is latched, and that channel is withheld from the valid mask until maintenance clears it with a repair pulse.

The outputs are a three-bit valid mask and a three-bit latched fault vector, meant for a downstream voter, plus a flag that reports when no two channels agree. The tolerance, the persistence count and the plausibility window are live inputs. Voting, tripping and supervision of time spent degraded all sit outside this block.

Top module: `chan_agree_mon`

## Requirements
- R1: `valid_o[i]` is 1 exactly when `lo_lim_i <= speed of channel i <= hi_lim_i` (both limits inclusive) and `fault_o[i]` is 0. It is combinational from the current inputs.
- R2: On a strobe, channel i is an outlier when its absolute difference from each of the other two channels is strictly greater than `tol_i`, and those two channels differ by at most `tol_i`. A difference equal to `tol_i` counts as agreement.
- R3: `fault_o[i]` goes to 1 at the clock edge of the strobe that completes `persist_i` consecutive outlier strobes for channel i. A `persist_i` of 0 behaves like 1.
- R4: A strobe on which channel i is not an outlier restarts its consecutive count from zero. Cycles without a strobe neither advance nor restart the count.
- R5: Once set, `fault_o[i]` stays at 1 until `repair_i[i]` is high at a clock edge. The repair clears both the fault and the count, and it takes priority over a fault being set on the same edge.
- R6: While `fault_o[i]` is 1, `valid_o[i]` is 0, even when the channel's value is in range.
- R7: `no_consensus_o` is loaded on every strobe. It is 1 when all three pairwise differences exceed `tol_i`, and in that case no channel counts as an outlier. Between strobes it holds its value.
- R8: After reset, `fault_o` is 000 and `no_consensus_o` is 0, and all counts are zero.
- R9: At most one channel's fault can become set at a single clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_i | input | 1 | Sample strobe; the cross-comparison is evaluated when it is high |
| spd0_i | input | W | Channel 0 speed, unsigned |
| spd1_i | input | W | Channel 1 speed, unsigned |
| spd2_i | input | W | Channel 2 speed, unsigned |
| tol_i | input | W | Largest difference that still counts as agreement |
| persist_i | input | CNT_W | Number of consecutive outlier strobes needed before a fault is latched |
| lo_lim_i | input | W | Lowest plausible speed |
| hi_lim_i | input | W | Highest plausible speed |
| repair_i | input | 3 | Per-channel maintenance clear of the latched fault |
| valid_o | output | 3 | Per-channel valid mask for the voter |
| fault_o | output | 3 | Per-channel latched fault |
| no_consensus_o | output | 1 | All three channels disagree, as of the last strobe |

## Verification
The assertions assume that `repair_i` is driven only to clear faults and that it carries no X after reset. The fault-monotonicity properties rely on faults appearing only at strobed edges. The bench changes inputs only on falling edges and holds `tol_i`, `persist_i` and the limits steady across each scenario. It raises one repair bit at a time, and it builds every outlier pattern so that at most one channel is isolated. This keeps the single-new-fault property inside conditions the block can actually produce.

// File: rtl/chan_agree_pkg.sv
package chan_agree_pkg;
  localparam int NCH   = 3;
  localparam int NPAIR = 3;
  // pair k compares channels (pa(k), pb(k)) and leaves out channel 2-k
  function automatic int pa(input int k);
    return (k == 2) ? 1 : 0;
  endfunction
  function automatic int pb(input int k);
    return (k == 0) ? 1 : 2;
  endfunction
endpackage

// File: rtl/speed_range_chk.sv
module speed_range_chk #(
  parameter int W = 16
) (
  input  logic [W-1:0] val_i,
  input  logic [W-1:0] lo_i,
  input  logic [W-1:0] hi_i,
  output logic         in_range_o
);
  always_comb in_range_o = (val_i >= lo_i) && (val_i <= hi_i);
endmodule

// File: rtl/speed_pair_cmp.sv
module speed_pair_cmp #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic [W-1:0] tol_i,
  output logic         apart_o
);
  logic [W-1:0] gap;
  always_comb begin
    gap     = (a_i >= b_i) ? (a_i - b_i) : (b_i - a_i);
    apart_o = gap > tol_i;
  end
endmodule

// File: rtl/outlier_latch.sv
module outlier_latch #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic             outlier_i,
  input  logic             repair_i,
  input  logic [CNT_W-1:0] persist_i,
  output logic             fault_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d, limit;
  logic             flt_q, flt_d;

  always_comb begin
    limit = (persist_i == '0) ? CNT_W'(1) : persist_i;
    cnt_d = cnt_q;
    flt_d = flt_q;
    if (repair_i) begin
      cnt_d = '0;
      flt_d = 1'b0;
    end else if (sample_i) begin
      if (outlier_i) begin
        if (cnt_q < limit) cnt_d = cnt_q + CNT_W'(1);
        if (cnt_d >= limit) flt_d = 1'b1;
      end else begin
        cnt_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      flt_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      flt_q <= flt_d;
    end
  end

  assign fault_o = flt_q;
endmodule

// File: rtl/chan_agree_mon.sv
module chan_agree_mon
  import chan_agree_pkg::*;
#(
  parameter int W     = 16,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sample_i,
  input  logic [W-1:0]     spd0_i,
  input  logic [W-1:0]     spd1_i,
  input  logic [W-1:0]     spd2_i,
  input  logic [W-1:0]     tol_i,
  input  logic [CNT_W-1:0] persist_i,
  input  logic [W-1:0]     lo_lim_i,
  input  logic [W-1:0]     hi_lim_i,
  input  logic [2:0]       repair_i,
  output logic [2:0]       valid_o,
  output logic [2:0]       fault_o,
  output logic             no_consensus_o
);
  logic [W-1:0]     spd [NCH];
  logic [NCH-1:0]   in_range, outlier;
  logic [NPAIR-1:0] apart;
  logic             nc_q, nc_d;

  always_comb begin
    spd[0] = spd0_i;
    spd[1] = spd1_i;
    spd[2] = spd2_i;
  end

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    speed_pair_cmp #(.W(W)) u_cmp (
      .a_i(spd[pa(k)]), .b_i(spd[pb(k)]), .tol_i(tol_i), .apart_o(apart[k])
    );
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    localparam logic [NPAIR-1:0] PATTERN = ~(NPAIR'(1) << (2 - i));
    speed_range_chk #(.W(W)) u_rng (
      .val_i(spd[i]), .lo_i(lo_lim_i), .hi_i(hi_lim_i), .in_range_o(in_range[i])
    );
    always_comb outlier[i] = (apart == PATTERN);
    outlier_latch #(.CNT_W(CNT_W)) u_lat (
      .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .outlier_i(outlier[i]),
      .repair_i(repair_i[i]), .persist_i(persist_i), .fault_o(fault_o[i])
    );
    always_comb valid_o[i] = in_range[i] && !fault_o[i];
  end

  always_comb nc_d = sample_i ? (&apart) : nc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nc_q <= 1'b0;
    else        nc_q <= nc_d;
  end

  assign no_consensus_o = nc_q;
endmodule

// File: rtl/chan_agree_mon_chk.sv
module chan_agree_mon_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       sample_i,
  input logic [2:0] repair_i,
  input logic [2:0] valid_o,
  input logic [2:0] fault_o,
  input logic       no_consensus_o
);
  for (genvar i = 0; i < 3; i++) begin : g_c
    // R5
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o[i] && !repair_i[i] |=> fault_o[i]);
    // R5
    repair_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      repair_i[i] |=> !fault_o[i]);
    // R3
    fault_on_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o[i]) |-> $past(sample_i));
    // R6
    fault_blocks_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fault_o[i] |-> !valid_o[i]);
    // R7
    nc_excludes_new_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fault_o[i]) |-> !no_consensus_o);
  end
  // R7
  nc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sample_i) |-> $stable(no_consensus_o));
  // R9
  single_new_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(fault_o & ~$past(fault_o)));
endmodule

bind chan_agree_mon chan_agree_mon_chk u_chk (
  .clk(clk), .rst_n(rst_n), .sample_i(sample_i), .repair_i(repair_i),
  .valid_o(valid_o), .fault_o(fault_o), .no_consensus_o(no_consensus_o)
);

// File: tb/chan_agree_mon_bench.sv
module chan_agree_mon_bench;
  localparam int W = 16, CNT_W = 8;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, sample_i = 1'b0;
  logic [W-1:0] spd0_i = '0, spd1_i = '0, spd2_i = '0;
  logic [W-1:0] tol_i = 16'd50, lo_lim_i = 16'd100, hi_lim_i = 16'd60000;
  logic [CNT_W-1:0] persist_i = 8'd3;
  logic [2:0] repair_i = 3'b000;
  logic [2:0] valid_o, fault_o;
  logic no_consensus_o;
  int errs = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chan_agree_mon #(.W(W), .CNT_W(CNT_W)) u_chan_agree_mon (.*);

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic setv(input int a, input int b, input int c);
    spd0_i = W'(a); spd1_i = W'(b); spd2_i = W'(c);
  endtask

  // one strobe: set inputs at falling edge, strobe over one rising edge
  task automatic strobe(input int a, input int b, input int c);
    @(negedge clk);
    setv(a, b, c);
    sample_i = 1'b1;
    @(negedge clk);
    sample_i = 1'b0;
    #1;
  endtask

  task automatic repair(input logic [2:0] m);
    @(negedge clk); repair_i = m;
    @(negedge clk); repair_i = 3'b000; #1;
  endtask

  task automatic t_reset();
    chk("R8 fault", fault_o, 3'b000);
    chk("R8 nc", no_consensus_o, 1'b0);
  endtask

  task automatic t_range();
    @(negedge clk); setv(50, 100, 60000); #1;
    chk("R1 low/edges", valid_o, 3'b110);
    setv(60001, 99, 1000); #1;
    chk("R1 high", valid_o, 3'b100);
  endtask

  task automatic t_persist();
    persist_i = 8'd3;
    strobe(1000, 1010, 1500);
    strobe(1000, 1010, 1500);
    strobe(1000, 1010, 1020);   // agreeing sample restarts count
    strobe(1000, 1010, 1500);
    strobe(1000, 1010, 1500);
    chk("R4 restart", fault_o, 3'b000);
    repeat (4) @(negedge clk);  // no strobe: no progress
    #1 chk("R4 idle", fault_o, 3'b000);
    strobe(1000, 1010, 1500);
    chk("R3 latch ch2", fault_o, 3'b100);
    chk("R6 valid masked", valid_o, 3'b011);
    strobe(1000, 1010, 1020);
    chk("R5 holds", fault_o, 3'b100);
  endtask

  task automatic t_repair();
    @(negedge clk); setv(1000, 1010, 1500); sample_i = 1'b1; repair_i = 3'b100;
    @(negedge clk); sample_i = 1'b0; repair_i = 3'b000; #1;
    chk("R5 repair priority", fault_o, 3'b000);
    chk("R1 valid back", valid_o, 3'b111);
    strobe(1000, 1010, 1500);
    strobe(1000, 1010, 1500);
    chk("R5 count cleared", fault_o, 3'b000);
    strobe(1000, 1010, 1500);
    chk("R3 relatch", fault_o, 3'b100);
    repair(3'b100);
    chk("R5 repair", fault_o, 3'b000);
  endtask

  task automatic t_tol_edge();
    persist_i = 8'd1;
    strobe(1000, 1000, 1050);
    chk("R2 equal tol", fault_o, 3'b000);
    strobe(1051, 1000, 1000);
    chk("R2 ch0 outlier", fault_o, 3'b001);
    repair(3'b001);
    strobe(1000, 1030, 1060);   // 0-2 apart but peers near middle
    chk("R2 no single outlier", fault_o, 3'b000);
  endtask

  task automatic t_nc();
    persist_i = 8'd1;
    strobe(1000, 2000, 3000);
    chk("R7 nc set", no_consensus_o, 1'b1);
    chk("R7 no fault", fault_o, 3'b000);
    repeat (3) @(negedge clk);
    #1 chk("R7 nc holds", no_consensus_o, 1'b1);
    strobe(1000, 1000, 1000);
    chk("R7 nc clear", no_consensus_o, 1'b0);
  endtask

  task automatic t_zero();
    persist_i = 8'd0;
    strobe(1000, 900, 1000);
    chk("R3 zero as one", fault_o, 3'b010);
    repair(3'b010);
    chk("R5 clear ch1", fault_o, 3'b000);
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1'b1;
    t_range();
    t_persist();
    t_repair();
    t_tol_edge();
    t_nc();
    t_zero();
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule